// File: doc/BRIEF.md
# Dual General-Purpose I/O Port Pair

This block gives a processor two 8-bit general-purpose ports, A and B, on a small memory-mapped bus. Each port has an output-data register and a direction register. A direction bit of 1 makes that pin an output that drives the stored data bit. A direction bit of 0 makes the pin an input, and the block drives it high on its output side, as a pull-up would. Reads return the stored data on output pins and the sampled pin level on input pins, so software always sees the true state of each pin.

The bus has a 5-bit address, a write strobe, a read strobe, a read-modify-write qualifier and separate 8-bit write and read data paths. Read data is registered. A read-modify-write instruction writes twice on a real bus: it first writes the value it just read, and then writes the modified value. When the qualifier comes with a write, a two-state sequencer replays that pattern. The write sequencer has two states. ST_IDLE accepts bus writes. ST_REPLAY performs the second write of a read-modify-write. The transition IDLE_TO_REPLAY is taken on a write with the qualifier set. The transition REPLAY_TO_IDLE is always taken after one cycle. A plain write stays in ST_IDLE.

Addresses with bit 2 set belong to other functions that share the address space (timers, edge detection). This block ignores them.

Top module: `gpio2_pair`

## Requirements
- R1: While reset is asserted and after it is released, all four registers hold 0, both ports drive 8'hFF, and the read data output is 0.
- R2: The block decodes only address bits 2:0. When bit 2 is 0, bits 1:0 select the register: 0 is the port A data register, 1 is the port A direction register, 2 is the port B data register and 3 is the port B direction register. Address bits 4:3 have no effect.
- R3: A write whose address has bit 2 set changes no register, and neither port output changes.
- R4: Each port drives its data register OR the bitwise complement of its direction register. A direction bit of 1 means output.
- R5: A write to the data register or the direction register of a port changes that port's driven value on the clock edge that takes the write.
- R6: A read of a data-register address captures, on its clock edge, the data bit where the direction bit is 1 and the sampled pin level where it is 0. The read data output holds that value until the next read.
- R7: A read of a direction register returns its stored value. A read whose address has bit 2 set returns 0.
- R8: A write with the read-modify-write qualifier set first writes the current read data output (the last value read) to the addressed register, on that clock edge. It then writes the supplied new value on the following edge (ST_IDLE to ST_REPLAY and back).
- R9: A write strobe presented during the ST_REPLAY cycle is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Register address; only bits 2:0 decoded |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rmw_i | input | 1 | Marks the write as the tail of a read-modify-write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, also the last value read |
| pa_pins_i | input | 8 | Sampled pin levels of port A |
| pb_pins_i | input | 8 | Sampled pin levels of port B |
| pa_o | output | 8 | Driven value of port A |
| pb_o | output | 8 | Driven value of port B |

## Verification
Some checks run on every cycle. These are the driven values during reset, the all-high result of clearing a direction register, the stability of both ports after a write to an address with bit 2 set, the hold of the read data between reads, and the single-cycle visit to ST_REPLAY. The bench's scenarios are needed for the rest. They show that every tested mix of data and direction values drives the right pins on both ports, and that address bits 4:3 are ignored. They show the value a read returns for mixed pin directions. They show the order of a read-modify-write: the old read value appears on the pins for one cycle before the new value. They also show that a write during the replay cycle is dropped.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;

    // Address bits the block decodes; bit 2 selects this block (0) or a neighbour (1)
    localparam int DEC_W   = 3;
    localparam int SEL_BIT = 2;
    localparam int PORT_BIT = 1;
    localparam int DIR_BIT  = 0;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPLAY = 1'b1
    } wr_state_e;

endpackage

// File: rtl/gpio2_port.sv
module gpio2_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_out,
    input  logic          we_dir,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] pins_i,
    output logic [DW-1:0] drive_o,
    output logic [DW-1:0] rd_port_o,
    output logic [DW-1:0] rd_dir_o
);

    logic [DW-1:0] out_q;
    logic [DW-1:0] dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (we_out) out_q <= wdata_i;
            if (we_dir) dir_q <= wdata_i;
        end
    end

    // Input pins float high on the output side
    assign drive_o   = out_q | ~dir_q;
    // Output pins read back the register, input pins read the sampled level
    assign rd_port_o = (out_q & dir_q) | (pins_i & ~dir_q);
    assign rd_dir_o  = dir_q;

endmodule

// File: rtl/gpio2_wr_seq.sv
module gpio2_wr_seq
    import gpio2_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             rmw_i,
    input  logic [DEC_W-1:0] addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    last_rd_i,
    output logic             wr_en_o,
    output logic [DEC_W-1:0] wr_addr_o,
    output logic [DW-1:0]    wr_data_o,
    output logic             busy_o
);

    wr_state_e        state_q, state_d;
    logic [DEC_W-1:0] pend_addr_q;
    logic [DW-1:0]    pend_data_q;
    logic             start_rmw;

    assign start_rmw = (state_q == ST_IDLE) && wr_i && rmw_i;

    // State register and pending second write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_rmw) begin
                pend_addr_q <= addr_i;
                pend_data_q <= wdata_i;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_rmw) state_d = ST_REPLAY;   // IDLE_TO_REPLAY
            ST_REPLAY: state_d = ST_IDLE;                    // REPLAY_TO_IDLE
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = addr_i;
        wr_data_o = wdata_i;
        busy_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_en_o = wr_i;
                // First write of a read-modify-write restores the value read
                if (rmw_i) wr_data_o = last_rd_i;
            end
            ST_REPLAY: begin
                wr_en_o   = 1'b1;
                wr_addr_o = pend_addr_q;
                wr_data_o = pend_data_q;
                busy_o    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio2_pair.sv
module gpio2_pair
    import gpio2_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic          rmw_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [DW-1:0] pa_pins_i,
    input  logic [DW-1:0] pb_pins_i,
    output logic [DW-1:0] pa_o,
    output logic [DW-1:0] pb_o
);

    localparam int NPORT = 2;

    logic             wr_en;
    logic [DEC_W-1:0] wr_addr;
    logic [DW-1:0]    wr_data;
    logic             wr_busy;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    rd_mux;
    logic             unused_hi_addr;

    logic [DW-1:0] pins_arr  [NPORT];
    logic [DW-1:0] drive_arr [NPORT];
    logic [DW-1:0] rdp_arr   [NPORT];
    logic [DW-1:0] rdd_arr   [NPORT];

    assign unused_hi_addr = ^addr_i[AW-1:DEC_W];

    assign pins_arr[0] = pa_pins_i;
    assign pins_arr[1] = pb_pins_i;

    gpio2_wr_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .rmw_i     (rmw_i),
        .addr_i    (addr_i[DEC_W-1:0]),
        .wdata_i   (wdata_i),
        .last_rd_i (rdata_q),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .busy_o    (wr_busy)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic hit;
        assign hit = wr_en && !wr_addr[SEL_BIT] && (wr_addr[PORT_BIT] == 1'(g));

        gpio2_port #(.DW(DW)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_out    (hit && !wr_addr[DIR_BIT]),
            .we_dir    (hit &&  wr_addr[DIR_BIT]),
            .wdata_i   (wr_data),
            .pins_i    (pins_arr[g]),
            .drive_o   (drive_arr[g]),
            .rd_port_o (rdp_arr[g]),
            .rd_dir_o  (rdd_arr[g])
        );
    end

    assign pa_o = drive_arr[0];
    assign pb_o = drive_arr[1];

    always_comb begin
        if (addr_i[SEL_BIT])      rd_mux = '0;
        else if (addr_i[DIR_BIT]) rd_mux = rdd_arr[addr_i[PORT_BIT]];
        else                      rd_mux = rdp_arr[addr_i[PORT_BIT]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio2_pair_chk.sv
module gpio2_pair_chk #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          wr_i,
    input logic          rd_i,
    input logic          rmw_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] rdata_o,
    input logic [DW-1:0] pa_o,
    input logic [DW-1:0] pb_o,
    input logic          busy
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen <= 1'b1;
    end

    // R1: reset leaves every pin an input, driven high, and no read data
    always @(posedge clk) begin
        if (!rst_n && rst_seen === 1'b1) begin
            assert_reset_state_R1: assert (pa_o == '1 && pb_o == '1 && rdata_o == '0);
        end
    end

    // R4: clearing port A direction register turns every pin of A high
    assert_dir_clear_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_i && !rmw_i && addr_i[2:0] == 3'b001 && wdata_i == '0) |=> (pa_o == '1));

    // R3: a write to an address with bit 2 set leaves both ports untouched
    assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_i && addr_i[2]) |=> ($stable(pa_o) && $stable(pb_o)));

    // R6: read data holds while no read is issued
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // R8: a qualified write enters the replay cycle
    assert_rmw_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_i && rmw_i) |=> busy);

    // R8: the replay cycle lasts exactly one cycle
    assert_rmw_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

bind gpio2_pair gpio2_pair_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .rmw_i   (rmw_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pa_o    (pa_o),
    .pb_o    (pb_o),
    .busy    (wr_busy)
);

// File: tb/gpio2_pair_tb_top.sv
module gpio2_pair_tb_top;

    localparam int DW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0, rd = 1'b0, rmw = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] pa_pins = '0, pb_pins = '0;
    logic [DW-1:0] rdata, pa, pb;

    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_en = 1'b0;
    string cur_req = "R1";

    // Reference state: index 0 A data, 1 A dir, 2 B data, 3 B dir
    logic [DW-1:0] m_reg [4];
    logic [DW-1:0] m_rd;

    always #4 clk = ~clk;

    gpio2_pair #(.DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .rmw_i(rmw),
        .wdata_i(wdata), .rdata_o(rdata), .pa_pins_i(pa_pins), .pb_pins_i(pb_pins),
        .pa_o(pa), .pb_o(pb)
    );

    function automatic logic [DW-1:0] m_pin(int p);
        return m_reg[2*p] | ~m_reg[2*p+1];
    endfunction

    function automatic logic [DW-1:0] m_read(logic [AW-1:0] a);
        int p;
        logic [DW-1:0] lv;
        if (a[2]) return '0;
        p = int'(a[1]);
        if (a[0]) return m_reg[2*p+1];
        lv = (p == 1) ? pb_pins : pa_pins;
        return (m_reg[2*p] & m_reg[2*p+1]) | (lv & ~m_reg[2*p+1]);
    endfunction

    task automatic check8(string name, logic [DW-1:0] act, logic [DW-1:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%02h expected=%02h t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            vectors++;
            check8("pa_o",    pa,    m_pin(0));
            check8("pb_o",    pb,    m_pin(1));
            check8("rdata_o", rdata, m_rd);
        end
    end

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0; rmw = 1'b0;
        @(posedge clk); #1;
        if (!a[2]) m_reg[a[1:0]] = d;
    endtask

    task automatic do_read(logic [AW-1:0] a);
        @(negedge clk);
        addr = a; wr = 1'b0; rd = 1'b1; rmw = 1'b0;
        @(posedge clk);
        m_rd = m_read(a);
        #1;
    endtask

    task automatic do_rmw(logic [AW-1:0] a, logic [DW-1:0] d, bit intrude,
                          logic [AW-1:0] a2, logic [DW-1:0] d2);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; rd = 1'b0; rmw = 1'b1;
        @(posedge clk); #1;
        if (!a[2]) m_reg[a[1:0]] = m_rd;          // old value first
        @(negedge clk);                            // pins show the replayed value here
        rmw = 1'b0;
        if (intrude) begin addr = a2; wdata = d2; wr = 1'b1; end
        else wr = 1'b0;
        @(posedge clk); #1;
        if (!a[2]) m_reg[a[1:0]] = d;             // then the new value
    endtask

    task automatic do_idle();
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; rmw = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 20000);
        miscompares++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [DW-1:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_rd = '0;

        // R1: state during and after reset
        cur_req = "R1";
        repeat (2) @(posedge clk);
        @(negedge clk); chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_idle(); do_idle();

        // R4 / R5: every pairing of data and direction patterns on both ports
        cur_req = "R4";
        for (int o = 0; o < 4; o++) begin
            for (int d = 0; d < 4; d++) begin
                do_write(5'd0, pats[o]);
                do_write(5'd1, pats[d] ^ 8'h0F);
                do_write(5'd2, ~pats[d]);
                do_write(5'd3, pats[o] ^ pats[d]);
            end
        end
        cur_req = "R5";
        do_write(5'd1, 8'hFF);
        do_write(5'd0, 8'h5A);
        do_write(5'd3, 8'hF0);
        do_write(5'd2, 8'h81);

        // R2: address bits 4:3 ignored
        cur_req = "R2";
        do_write(5'b11000, 8'h12);
        do_write(5'b01001, 8'hC3);
        do_write(5'b10010, 8'h34);
        do_write(5'b11011, 8'h0F);

        // R3: writes to neighbour addresses leave the ports alone
        cur_req = "R3";
        for (int k = 4; k < 8; k++) do_write(AW'(k), 8'hEE);
        do_write(5'b10100, 8'h00);
        do_write(5'b11111, 8'h00);
        do_idle();

        // R6: port reads mix register and pins
        cur_req = "R6";
        pa_pins = 8'h6C; pb_pins = 8'h93;
        do_read(5'd0);
        do_idle(); do_idle();
        do_read(5'd2);
        pa_pins = 8'hFF; pb_pins = 8'h00;
        do_read(5'b11000);
        do_read(5'b01010);

        // R7: direction reads and neighbour reads
        cur_req = "R7";
        do_read(5'd1);
        do_read(5'd3);
        do_read(5'd4);
        do_read(5'b10111);

        // R8: read-modify-write writes the old value, then the new one
        cur_req = "R8";
        do_write(5'd1, 8'h0F);
        do_write(5'd0, 8'h05);
        pa_pins = 8'hA0;
        do_read(5'd0);                 // returns A5, differs from register 05
        do_rmw(5'd0, 8'h3C, 1'b0, '0, '0);
        do_idle();
        pb_pins = 8'h70;
        do_read(5'd3);                 // returns port B direction
        do_rmw(5'd3, 8'h55, 1'b0, '0, '0);
        do_read(5'd2);
        do_rmw(5'd2, 8'hC6, 1'b0, '0, '0);
        do_idle();

        // R9: a write during the replay cycle is dropped
        cur_req = "R9";
        do_read(5'd1);
        do_rmw(5'd1, 8'hF3, 1'b1, 5'd0, 8'h99);
        do_idle();
        do_read(5'd0);
        do_rmw(5'd0, 8'h11, 1'b1, 5'd3, 8'h00);
        do_idle(); do_idle();

        chk_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule